// File: doc/BRIEF.md
# Timer Count-Clock Selector with Pin Edge Qualification

This block decides, cycle by cycle, when a 16-bit timer/event counter advances and when its two external input pins deliver a capture trigger. A 2-bit source field chooses the counting rate. The counter can run on every system clock, on one pulse per 16 clocks, on one pulse per 64 clocks, or on the qualified edges of the first external pin. Each pin has its own 2-bit edge field. That field chooses falling edges, rising edges or both edges, and one code is reserved.

Both pins pass through a two-flop synchronizer and a two-sample stability filter before edge detection, so that short glitches are dropped. The configuration can be written only while the timer is stopped. The first enable after reset treats a pin that is already high as a fresh rising edge. Any later enable does not.

The counter logic supplies a flag that says it uses the first pin's edge for clear-and-start. When that flag is set and the same pin's edge is also the count source, the block raises a configuration error. It raises the same error when either edge field holds the reserved code.

Top module: `tps_timer_clk_sel`

## Requirements
- R1: After reset `cfgQ` is 0, `countEn`, `captureA` and `captureB` are 0, and `cfgErr` is 0 when `clearStartOnA` is low.
- R2: A write on `cfgWrEn` updates `cfgQ` only when `timerRun` is low. A write made while `timerRun` is high leaves `cfgQ` unchanged. Field positions: bits [1:0] are the count source, bits [3:2] are the pin A edge code, and bits [5:4] are the pin B edge code.
- R3: With count source 00 and `timerRun` high, `countEn` is high in every cycle.
- R4: Count source 01 gives one single-cycle `countEn` pulse every 16 cycles. Count source 10 gives one pulse every 64 cycles.
- R5: Count source 11 makes `countEn` pulse exactly when `captureA` pulses, that is, on each valid pin A edge.
- R6: The edge codes are 00 for falling, 01 for rising, 11 for both, and 10 for none. A valid edge produces a one-cycle strobe, which is high after the fifth rising clock edge following the pin change.
- R7: A pin level held for only one clock is rejected. A level held for three clocks is accepted.
- R8: On the first enable after reset, a pin that is already high and set for rising edges gives one capture strobe.
- R9: When the timer is enabled again after a stop, a pin that is already high gives no strobe.
- R10: `cfgErr` is high when either edge code is 10, or when the count source is 11 while `clearStartOnA` is high.
- R11: While `timerRun` is low, `countEn`, `captureA` and `captureB` stay low whatever the pins do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timerRun | input | 1 | Timer enabled |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 6 | Configuration write value |
| clearStartOnA | input | 1 | Counter uses the pin A edge for clear-and-start |
| pinA | input | 1 | External count/capture pin A |
| pinB | input | 1 | External capture pin B |
| cfgQ | output | 6 | Current configuration |
| cfgErr | output | 1 | Configuration is illegal |
| countEn | output | 1 | Count-enable strobe |
| captureA | output | 1 | Valid edge on pin A |
| captureB | output | 1 | Valid edge on pin B |

## Verification
With count source 11, a single qualified pin A transition must raise `countEn` and `captureA` in the same cycle. The bench toggles pin A under the both-edges and rising-only codes and counts both strobes in the same windows. A check fails if the two counts differ or if either strobe lands anywhere other than the fifth cycle after the change. The first-enable rule is also tested where it collides with an edge: enabling with the pin high must yield a strobe once after reset and never again.

// File: rtl/tps_pkg.sv
`timescale 1ns/1ps
package tps_pkg;
  localparam int NUM_PINS = 2;
  localparam int FIELD_W  = 2;
  localparam int CFG_W    = FIELD_W * (NUM_PINS + 1);

  typedef enum logic [FIELD_W-1:0] {
    SRC_FULL  = 2'b00,
    SRC_DIVLO = 2'b01,
    SRC_DIVHI = 2'b10,
    SRC_PIN   = 2'b11
  } clkSrc_e;

  typedef enum logic [FIELD_W-1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_NONE = 2'b10,
    EDGE_BOTH = 2'b11
  } edgeSel_e;

  typedef struct packed {
    logic                             run;
    logic                             seedLow;
    logic [FIELD_W-1:0]               clkSrc;
    logic [NUM_PINS-1:0][FIELD_W-1:0] edgeSel;
  } ctlStrb_t;
endpackage

// File: rtl/tps_prescaler.sv
`timescale 1ns/1ps
module tps_prescaler #(
  parameter int PRE_W  = 6,
  parameter int TAP_LO = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tickLo,
  output logic tickHi
);
  logic [PRE_W-1:0] preCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) preCnt <= '0;
    else        preCnt <= preCnt + 1'b1;
  end

  assign tickLo = &preCnt[TAP_LO-1:0];
  assign tickHi = &preCnt;
endmodule

// File: rtl/tps_pin_filter.sv
`timescale 1ns/1ps
module tps_pin_filter #(
  parameter int SYNC_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pinIn,
  input  logic run,
  input  logic seedLow,
  output logic rise,
  output logic fall
);
  logic [SYNC_LEN-1:0] syncChain;
  logic lastSample;
  logic filtLvl;
  logic prevLvl;
  logic syncOut;

  assign syncOut = syncChain[SYNC_LEN-1];

  generate
    if (SYNC_LEN == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) syncChain <= '0;
        else        syncChain <= pinIn;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) syncChain <= '0;
        else        syncChain <= {syncChain[SYNC_LEN-2:0], pinIn};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lastSample <= 1'b0;
      filtLvl    <= 1'b0;
      prevLvl    <= 1'b0;
    end else begin
      lastSample <= syncOut;
      if (syncOut == lastSample) filtLvl <= syncOut;
      // before the very first enable the previous level is pinned low
      if (!run && seedLow) prevLvl <= 1'b0;
      else                 prevLvl <= filtLvl;
    end
  end

  assign rise = filtLvl & ~prevLvl;
  assign fall = ~filtLvl & prevLvl;
endmodule

// File: rtl/tps_control.sv
`timescale 1ns/1ps
module tps_control
  import tps_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             timerRun,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             clearStartOnA,
  output logic [CFG_W-1:0] cfgQ,
  output logic             cfgErr,
  output ctlStrb_t         ctl
);
  logic [CFG_W-1:0] cfgReg;
  logic             firstDone;
  logic [NUM_PINS-1:0] badCode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgReg    <= '0;
      firstDone <= 1'b0;
    end else begin
      if (cfgWrEn && !timerRun) cfgReg <= cfgWrData;
      if (timerRun) firstDone <= 1'b1;
    end
  end

  assign ctl.run     = timerRun;
  assign ctl.seedLow = ~firstDone;
  assign ctl.clkSrc  = cfgReg[FIELD_W-1:0];

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_field
      assign ctl.edgeSel[p] = cfgReg[FIELD_W*(p+1) +: FIELD_W];
      assign badCode[p]     = (cfgReg[FIELD_W*(p+1) +: FIELD_W] == EDGE_NONE);
    end
  endgenerate

  assign cfgQ   = cfgReg;
  assign cfgErr = (|badCode) || (clearStartOnA && (ctl.clkSrc == SRC_PIN));
endmodule

// File: rtl/tps_datapath.sv
`timescale 1ns/1ps
module tps_datapath
  import tps_pkg::*;
#(
  parameter int PRE_W    = 6,
  parameter int TAP_LO   = 4,
  parameter int SYNC_LEN = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctlStrb_t            ctl,
  input  logic [NUM_PINS-1:0] pins,
  output logic                countEn,
  output logic [NUM_PINS-1:0] capture
);
  logic tickLo, tickHi;
  logic [NUM_PINS-1:0] riseV, fallV, validV;
  logic countNext;

  tps_prescaler #(.PRE_W(PRE_W), .TAP_LO(TAP_LO)) u_pre (
    .clk(clk), .rst_n(rst_n), .tickLo(tickLo), .tickHi(tickHi)
  );

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      tps_pin_filter #(.SYNC_LEN(SYNC_LEN)) u_flt (
        .clk(clk), .rst_n(rst_n), .pinIn(pins[p]), .run(ctl.run),
        .seedLow(ctl.seedLow), .rise(riseV[p]), .fall(fallV[p])
      );
      always_comb begin
        unique case (edgeSel_e'(ctl.edgeSel[p]))
          EDGE_FALL: validV[p] = fallV[p];
          EDGE_RISE: validV[p] = riseV[p];
          EDGE_BOTH: validV[p] = riseV[p] | fallV[p];
          default:   validV[p] = 1'b0;
        endcase
      end
    end
  endgenerate

  always_comb begin
    unique case (clkSrc_e'(ctl.clkSrc))
      SRC_FULL:  countNext = 1'b1;
      SRC_DIVLO: countNext = tickLo;
      SRC_DIVHI: countNext = tickHi;
      default:   countNext = validV[0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      countEn <= 1'b0;
      capture <= '0;
    end else begin
      countEn <= ctl.run & countNext;
      capture <= ctl.run ? validV : '0;
    end
  end
endmodule

// File: rtl/tps_timer_clk_sel.sv
`timescale 1ns/1ps
module tps_timer_clk_sel
  import tps_pkg::*;
#(
  parameter int PRE_W    = 6,
  parameter int TAP_LO   = 4,
  parameter int SYNC_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             timerRun,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             clearStartOnA,
  input  logic             pinA,
  input  logic             pinB,
  output logic [CFG_W-1:0] cfgQ,
  output logic             cfgErr,
  output logic             countEn,
  output logic             captureA,
  output logic             captureB
);
  ctlStrb_t ctl;
  logic [NUM_PINS-1:0] capV;

  tps_control u_ctl (
    .clk(clk), .rst_n(rst_n), .timerRun(timerRun), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .clearStartOnA(clearStartOnA),
    .cfgQ(cfgQ), .cfgErr(cfgErr), .ctl(ctl)
  );

  tps_datapath #(.PRE_W(PRE_W), .TAP_LO(TAP_LO), .SYNC_LEN(SYNC_LEN)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .pins({pinB, pinA}),
    .countEn(countEn), .capture(capV)
  );

  assign captureA = capV[0];
  assign captureB = capV[1];
endmodule

// File: rtl/tps_checker.sv
`timescale 1ns/1ps
module tps_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       timerRun,
  input logic [5:0] cfgQ,
  input logic       countEn,
  input logic       captureA,
  input logic       captureB
);
  p_cfg_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    timerRun |=> $stable(cfgQ));

  p_stop_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !timerRun |=> (!countEn && !captureA && !captureB));

  p_div_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgQ[1:0] == 2'b01 && countEn) |=> !countEn);

  p_pin_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgQ[1:0] == 2'b11) |-> (countEn == captureA));

  p_none_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgQ[3:2] == 2'b10) |-> !captureA);

  p_strobe_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
    captureA |=> !captureA);
endmodule

bind tps_timer_clk_sel tps_checker u_chk (
  .clk(clk), .rst_n(rst_n), .timerRun(timerRun), .cfgQ(cfgQ),
  .countEn(countEn), .captureA(captureA), .captureB(captureB)
);

// File: tb/sim_tps_timer_clk_sel.sv
`timescale 1ns/1ps
module sim_tps_timer_clk_sel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic timerRun = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [5:0] cfgWrData = '0;
  logic clearStartOnA = 1'b0;
  logic pinA = 1'b1;
  logic pinB = 1'b1;
  logic [5:0] cfgQ;
  logic cfgErr, countEn, captureA, captureB;

  int nChecks = 0;
  int nErrors = 0;
  int nCnt, nCapA, nCapB, firstA, badGap;

  always #10 clk = ~clk;

  tps_timer_clk_sel u0 (
    .clk(clk), .rst_n(rst_n), .timerRun(timerRun), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .clearStartOnA(clearStartOnA), .pinA(pinA),
    .pinB(pinB), .cfgQ(cfgQ), .cfgErr(cfgErr), .countEn(countEn),
    .captureA(captureA), .captureB(captureB)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [5:0] v);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic runCount(input int n, input int gap);
    int lastIdx;
    nCnt = 0; nCapA = 0; nCapB = 0; firstA = 0; badGap = 0; lastIdx = -1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (countEn) begin
        if (gap != 0 && lastIdx >= 0 && (i - lastIdx) != gap) badGap++;
        lastIdx = i;
        nCnt++;
      end
      if (captureA) begin
        nCapA++;
        if (firstA == 0) firstA = i;
      end
      if (captureB) nCapB++;
    end
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cfgQ", cfgQ, 0);
    check("R1 countEn", countEn, 0);
    check("R1 captures", captureA | captureB, 0);
    check("R1 cfgErr", cfgErr, 0);
  endtask

  task automatic t_first_enable;
    writeCfg(6'h04);
    runCount(10, 0);
    check("R11 no capture while stopped", nCapA, 0);
    timerRun = 1'b1;
    runCount(8, 0);
    check("R8 first enable rising", nCapA, 1);
    check("R3 full rate count", nCnt, 8);
  endtask

  task automatic t_reenable;
    timerRun = 1'b0;
    runCount(4, 0);
    timerRun = 1'b1;
    runCount(8, 0);
    check("R9 re-enable no edge", nCapA, 0);
  endtask

  task automatic t_write_lock;
    writeCfg(6'h3F);
    check("R2 write ignored while running", cfgQ, 6'h04);
    timerRun = 1'b0;
    writeCfg(6'h01);
    check("R2 write accepted while stopped", cfgQ, 6'h01);
  endtask

  task automatic t_stopped;
    pinA = 1'b0; pinB = 1'b0;
    runCount(10, 0);
    check("R11 stopped countEn", nCnt, 0);
    check("R11 stopped captures", nCapA + nCapB, 0);
    pinA = 1'b1; pinB = 1'b1;
    runCount(10, 0);
    check("R11 stopped captures rise", nCapA + nCapB, 0);
  endtask

  task automatic t_dividers;
    timerRun = 1'b1;
    runCount(128, 16);
    check("R4 div16 pulses", nCnt, 8);
    check("R4 div16 spacing", badGap, 0);
    timerRun = 1'b0;
    writeCfg(6'h02);
    timerRun = 1'b1;
    runCount(256, 64);
    check("R4 div64 pulses", nCnt, 4);
    check("R4 div64 spacing", badGap, 0);
    timerRun = 1'b0;
  endtask

  task automatic t_pin_edges;
    writeCfg(6'h0F);
    check("R10 legal cfg no error", cfgErr, 0);
    timerRun = 1'b1;
    runCount(10, 0);
    check("R9 enable with pins high", nCapA + nCapB, 0);
    pinA = 1'b0;
    runCount(10, 0);
    check("R6 both edges fall", nCapA, 1);
    check("R6 strobe latency", firstA, 5);
    check("R5 count follows pin", nCnt, 1);
    pinA = 1'b1;
    runCount(10, 0);
    check("R6 both edges rise", nCapA, 1);
    check("R5 count on rise", nCnt, 1);
    pinB = 1'b0;
    runCount(10, 0);
    check("R6 pin B falling", nCapB, 1);
    pinB = 1'b1;
    runCount(10, 0);
    check("R6 pin B rise ignored", nCapB, 0);
    timerRun = 1'b0;
    writeCfg(6'h07);
    timerRun = 1'b1;
    pinA = 1'b0;
    runCount(10, 0);
    check("R6 rise-only skips fall", nCapA, 0);
    check("R5 no count on fall", nCnt, 0);
    pinA = 1'b1;
    runCount(10, 0);
    check("R6 rise-only rise", nCapA, 1);
    check("R5 count on rise only", nCnt, 1);
    timerRun = 1'b0;
  endtask

  task automatic t_errors;
    int total;
    writeCfg(6'h08);
    check("R10 pin A reserved code", cfgErr, 1);
    timerRun = 1'b1;
    pinA = 1'b0;
    runCount(10, 0);
    total = nCapA;
    pinA = 1'b1;
    runCount(10, 0);
    check("R6 reserved code no edges", total + nCapA, 0);
    timerRun = 1'b0;
    writeCfg(6'h20);
    check("R10 pin B reserved code", cfgErr, 1);
    writeCfg(6'h03);
    check("R10 pin source alone", cfgErr, 0);
    clearStartOnA = 1'b1;
    @(negedge clk);
    check("R10 pin source with clear-start", cfgErr, 1);
    writeCfg(6'h00);
    check("R10 clear-start with full rate", cfgErr, 0);
    clearStartOnA = 1'b0;
  endtask

  task automatic t_glitch;
    writeCfg(6'h0C);
    timerRun = 1'b1;
    runCount(6, 0);
    pinA = 1'b0;
    @(negedge clk);
    pinA = 1'b1;
    runCount(10, 0);
    check("R7 one-cycle pulse rejected", nCapA, 0);
    pinA = 1'b0;
    repeat (3) @(negedge clk);
    pinA = 1'b1;
    runCount(12, 0);
    check("R7 three-cycle pulse accepted", nCapA, 2);
    timerRun = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    t_reset();
    t_first_enable();
    t_reenable();
    t_write_lock();
    t_stopped();
    t_dividers();
    t_pin_edges();
    t_errors();
    t_glitch();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule